// File: doc/BRIEF.md
# Indexed Address Generator with Page-Cross Timing

This block forms effective addresses for an 8-bit processor that has a 16-bit address space but only an 8-bit adder. A start strobe delivers a 16-bit base, an 8-bit index or offset, and a mode. The mode is one of four: absolute indexed, zero-page indexed, relative branch or plain jump. The block adds the index into the low byte of the base only. When that add carries, or borrows in the case of a backward branch, the high byte is repaired in one extra clock. The block raises a page-cross flag for this case and reports how many bus cycles the instruction's addressing costs.

The block also holds the program counter. After reset, a small sequencer reads the low byte of the start address at FFFC and the high byte at FFFD, in that order. It loads the pair into the program counter and then marks the counter valid. From then on the counter advances by one through a plain incrementer on each step pulse.

Top module: `idx_addr_gen`

## Requirements
- R1: In absolute indexed mode (mode = 0), the final address is (base + index) mod 65536, with the index unsigned. `page_cross` is 1 exactly when base[7:0] + index exceeds 255.
- R2: `page_cross` is valid from the clock after an accepted start and holds until the next accepted start. With no page cross, `done` pulses one clock after the start and carries the final `ea`. With a page cross, the clock after the start shows `busy` = 1 and `ea` = {base[15:8], low sum}. On the clock after that, `done` pulses with the corrected `ea`.
- R3: In zero-page indexed mode (mode = 1), `ea` = {8'h00, (base[7:0] + index) mod 256}, `page_cross` = 0 and `cycles` = 4.
- R4: In branch mode (mode = 2) with `br_taken` = 1, the index is a two's-complement offset. `ea` = base + sign-extended offset, where base is the address of the next instruction. `page_cross` = 1 exactly when the high byte of `ea` differs from base[15:8], and `cycles` is 3, or 4 with a cross. With `br_taken` = 0, `ea` = base, `page_cross` = 0 and `cycles` = 2.
- R5: In jump mode (mode = 3), `ea` = base, `page_cross` = 0 and `cycles` = 3, whatever the base and index.
- R6: In absolute indexed mode, `cycles` is 4 without a page cross and 5 with one.
- R7: After reset, the block reads address FFFC and then FFFD with `vec_rd` high, one clock each. `pc` becomes {byte at FFFD, byte at FFFC}, and `pc_valid` rises on the clock after the second read.
- R8: While `pc_valid` = 1, every clock with `pc_step` = 1 increments `pc` by one, modulo 65536. Otherwise `pc` holds.
- R9: A start is ignored while `busy` = 1 or while `pc_valid` = 0. Ignored starts leave `ea`, `page_cross` and `cycles` unchanged and raise no `done`.
- R10: During reset, `ea` = 0, `page_cross` = 0, `done` = 0, `busy` = 0, `cycles` = 0 and `pc_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin an address computation |
| mode | input | 2 | 0 absolute indexed, 1 zero-page indexed, 2 branch, 3 jump |
| base | input | 16 | Base address, or next-instruction address for branches |
| index | input | 8 | Unsigned index, or signed branch offset |
| br_taken | input | 1 | Branch condition outcome |
| vec_data | input | 8 | Read data for the current `vec_addr`, valid in the same clock |
| pc_step | input | 1 | Advance the program counter by one |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | High byte needed a repair cycle |
| done | output | 1 | One-clock pulse with the final address |
| busy | output | 1 | High-byte repair cycle in progress |
| cycles | output | 3 | Bus cycles charged for the addressing |
| vec_rd | output | 1 | Start-vector read strobe |
| vec_addr | output | 16 | Start-vector read address |
| pc | output | 16 | Program counter |
| pc_valid | output | 1 | Program counter has been loaded |

## Verification
The assertions assume that `vec_data` answers the address on `vec_addr` within the same clock. They also assume the mode input is a defined 2-bit code whenever `start` is high. The bench serves the two vector bytes from a combinational lookup on `vec_addr`. It changes inputs only at falling edges and keeps `mode` a valid code at all times. It drives `start` on purpose during the repair cycle and before the vector load finishes, so that the ignore rule is tested with inputs that keep to the assumptions.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int CYC_W  = 3;

  typedef enum logic [1:0] {
    MD_ABS_IDX = 2'd0,
    MD_ZP_IDX  = 2'd1,
    MD_BRANCH  = 2'd2,
    MD_JUMP    = 2'd3
  } agu_mode_e;

  typedef enum logic [1:0] {
    VS_LO  = 2'd0,
    VS_HI  = 2'd1,
    VS_RUN = 2'd2
  } vec_state_e;
endpackage

// File: rtl/agu_low_add.sv
module agu_low_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry
);
  always_comb begin
    {carry, sum} = {1'b0, a} + {1'b0, b};
  end
endmodule

// File: rtl/agu_high_fix.sv
module agu_high_fix #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_in,
  input  logic         up,
  output logic [W-1:0] hi_out
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  always_comb begin
    if (up) hi_out = hi_in + ONE;
    else    hi_out = hi_in - ONE;
  end
endmodule

// File: rtl/agu_vec_seq.sv
module agu_vec_seq
  import agu_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          BW       = 8,
  parameter logic [15:0] VEC_BASE = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] vec_data,
  input  logic          pc_step,
  output logic          vec_rd,
  output logic [AW-1:0] vec_addr,
  output logic [AW-1:0] pc,
  output logic          pc_valid
);
  localparam logic [AW-1:0] ADDR_LO = AW'(VEC_BASE);
  localparam logic [AW-1:0] ADDR_HI = AW'(VEC_BASE) + AW'(1);
  localparam logic [AW-1:0] PC_ONE  = AW'(1);

  vec_state_e    state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          pc_en;

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    pc_en    = 1'b0;
    vec_rd   = 1'b0;
    vec_addr = ADDR_LO;
    unique case (state_q)
      VS_LO: begin
        vec_rd         = 1'b1;
        vec_addr       = ADDR_LO;
        pc_en          = 1'b1;
        pc_d[BW-1:0]   = vec_data;
        state_d        = VS_HI;
      end
      VS_HI: begin
        vec_rd         = 1'b1;
        vec_addr       = ADDR_HI;
        pc_en          = 1'b1;
        pc_d[AW-1:BW]  = vec_data;
        state_d        = VS_RUN;
      end
      default: begin
        pc_en = pc_step;
        pc_d  = pc_q + PC_ONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VS_LO;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_d;
    end
  end

  assign pc       = pc_q;
  assign pc_valid = (state_q == VS_RUN);

  AST_VEC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec_addr == ADDR_HI) |-> ($past(vec_rd) && $past(vec_addr) == ADDR_LO)); // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pc_valid) && $past(pc_step)) |-> (pc == $past(pc) + PC_ONE)); // R8
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pc_valid) && !$past(pc_step)) |-> $stable(pc)); // R8
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import agu_pkg::*;
#(
  parameter int          AW       = ADDR_W,
  parameter int          BW       = BYTE_W,
  parameter int          CW       = CYC_W,
  parameter logic [15:0] VEC_BASE = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [BW-1:0] index,
  input  logic          br_taken,
  input  logic [BW-1:0] vec_data,
  input  logic          pc_step,
  output logic [AW-1:0] ea,
  output logic          page_cross,
  output logic          done,
  output logic          busy,
  output logic [CW-1:0] cycles,
  output logic          vec_rd,
  output logic [AW-1:0] vec_addr,
  output logic [AW-1:0] pc,
  output logic          pc_valid
);
  localparam int HW = AW - BW;
  localparam logic [CW-1:0] CYC_NT   = CW'(2);
  localparam logic [CW-1:0] CYC_JMP  = CW'(3);
  localparam logic [CW-1:0] CYC_BR   = CW'(3);
  localparam logic [CW-1:0] CYC_IDX  = CW'(4);

  agu_mode_e     mode_in, mode_q, mode_d;
  logic [AW-1:0] ea_q, ea_d, ea_n;
  logic          cross_q, cross_d, cross_n;
  logic          done_q, done_d;
  logic          busy_q, busy_d;
  logic          up_q, up_d, up_n;
  logic [CW-1:0] cyc_q, cyc_d, cyc_n;
  logic [BW-1:0] lo_sum;
  logic          lo_carry;
  logic [HW-1:0] hi_fixed;
  logic          accept;

  assign mode_in = agu_mode_e'(mode);

  agu_low_add #(.W(BW)) u_low_add (
    .a     (base[BW-1:0]),
    .b     (index),
    .sum   (lo_sum),
    .carry (lo_carry)
  );

  agu_high_fix #(.W(HW)) u_high_fix (
    .hi_in  (ea_q[AW-1:BW]),
    .up     (up_q),
    .hi_out (hi_fixed)
  );

  agu_vec_seq #(.AW(AW), .BW(BW), .VEC_BASE(VEC_BASE)) u_vec_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_data (vec_data),
    .pc_step  (pc_step),
    .vec_rd   (vec_rd),
    .vec_addr (vec_addr),
    .pc       (pc),
    .pc_valid (pc_valid)
  );

  assign accept = start && !busy_q && pc_valid;

  // Address and timing of a fresh request, before any high-byte repair.
  always_comb begin
    ea_n    = base;
    cross_n = 1'b0;
    up_n    = 1'b1;
    cyc_n   = CYC_JMP;
    unique case (mode_in)
      MD_ABS_IDX: begin
        ea_n    = {base[AW-1:BW], lo_sum};
        cross_n = lo_carry;
        cyc_n   = CYC_IDX + CW'(lo_carry);
      end
      MD_ZP_IDX: begin
        ea_n  = {{HW{1'b0}}, lo_sum};
        cyc_n = CYC_IDX;
      end
      MD_BRANCH: begin
        if (br_taken) begin
          ea_n    = {base[AW-1:BW], lo_sum};
          up_n    = !index[BW-1];
          cross_n = index[BW-1] ? !lo_carry : lo_carry;
          cyc_n   = CYC_BR + CW'(cross_n);
        end else begin
          cyc_n = CYC_NT;
        end
      end
      default: begin
        ea_n  = base;
        cyc_n = CYC_JMP;
      end
    endcase
  end

  always_comb begin
    ea_d    = ea_q;
    cross_d = cross_q;
    up_d    = up_q;
    cyc_d   = cyc_q;
    mode_d  = mode_q;
    busy_d  = 1'b0;
    done_d  = 1'b0;
    if (busy_q) begin
      ea_d   = {hi_fixed, ea_q[BW-1:0]};
      done_d = 1'b1;
    end else if (accept) begin
      ea_d    = ea_n;
      cross_d = cross_n;
      up_d    = up_n;
      cyc_d   = cyc_n;
      mode_d  = mode_in;
      busy_d  = cross_n;
      done_d  = !cross_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q    <= '0;
      cross_q <= 1'b0;
      up_q    <= 1'b1;
      cyc_q   <= '0;
      mode_q  <= MD_ABS_IDX;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ea_q    <= ea_d;
      cross_q <= cross_d;
      up_q    <= up_d;
      cyc_q   <= cyc_d;
      mode_q  <= mode_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign ea         = ea_q;
  assign page_cross = cross_q;
  assign done       = done_q;
  assign busy       = busy_q;
  assign cycles     = cyc_q;

  AST_FIX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy)); // R2
  AST_BUSY_MEANS_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> page_cross); // R2
  AST_ZP_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == MD_ZP_IDX) |-> (ea[AW-1:BW] == '0 && !page_cross)); // R3
  AST_JMP_NO_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == MD_JUMP) |-> (!page_cross && cycles == CYC_JMP)); // R5
  AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles >= CYC_NT && cycles <= CW'(5))); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cycles) && $stable(page_cross))); // R9
endmodule

// File: tb/idx_addr_gen_tb.sv
module idx_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] base = 16'h0000;
  logic [7:0]  index = 8'h00;
  logic        br_taken = 1'b0;
  logic [7:0]  vec_data;
  logic        pc_step = 1'b0;
  logic [15:0] ea;
  logic        page_cross, done, busy, vec_rd, pc_valid;
  logic [2:0]  cycles;
  logic [15:0] vec_addr, pc;

  int checks = 0;
  int errors = 0;
  int cyc_count = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] vmem(input logic [15:0] a);
    if (a == 16'hFFFC) return 8'h34;
    if (a == 16'hFFFD) return 8'hC2;
    return 8'hEA;
  endfunction
  assign vec_data = vmem(vec_addr);

  idx_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .index(index), .br_taken(br_taken), .vec_data(vec_data), .pc_step(pc_step),
    .ea(ea), .page_cross(page_cross), .done(done), .busy(busy), .cycles(cycles),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .pc(pc), .pc_valid(pc_valid)
  );

  // Behavioural reference, advanced on every rising edge.
  int m_phase = 0;
  int m_pc = 0;
  int m_ea = 0;
  int m_fix = 0;
  int m_cyc = 0;
  bit m_cross = 0, m_done = 0, m_busy = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pc = 0; m_ea = 0; m_fix = 0; m_cyc = 0;
      m_cross = 0; m_done = 0; m_busy = 0;
    end else begin
      bit pcv_old;
      pcv_old = (m_phase == 2);
      if (m_phase == 0) begin
        m_pc = (m_pc & 16'hFF00) | vmem(16'hFFFC); m_phase = 1;
      end else if (m_phase == 1) begin
        m_pc = (m_pc & 16'h00FF) | (int'(vmem(16'hFFFD)) << 8); m_phase = 2;
      end else if (pc_step) begin
        m_pc = (m_pc + 1) & 16'hFFFF;
      end
      m_done = 0;
      if (m_busy) begin
        m_ea = m_fix; m_busy = 0; m_done = 1;
      end else if (start && pcv_old) begin
        int b, i, off, full, part;
        bit cr;
        b = int'(base); i = int'(index);
        part = (b & 16'hFF00) | ((b + i) & 8'hFF);
        cr = 0;
        case (mode)
          2'd0: begin full = (b + i) & 16'hFFFF; cr = (full >> 8) != (b >> 8); m_cyc = 4 + int'(cr); end
          2'd1: begin full = (b + i) & 8'hFF; m_cyc = 4; end
          2'd2: begin
            if (br_taken) begin
              off = (i >= 128) ? i - 256 : i;
              full = (b + off) & 16'hFFFF;
              cr = (full >> 8) != (b >> 8);
              m_cyc = 3 + int'(cr);
            end else begin
              full = b; m_cyc = 2;
            end
          end
          default: begin full = b; m_cyc = 3; end
        endcase
        m_cross = cr;
        if (cr) begin m_ea = part; m_fix = full; m_busy = 1; end
        else begin m_ea = full; m_done = 1; end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc_count, act, exp);
    end
  endtask

  // Compare every output on every clock, shortly after the edge.
  always begin
    @(posedge clk);
    #2;
    cyc_count++;
    if (!rst_n) begin
      chk("R10 ea", int'(ea), 0);
      chk("R10 flags", int'({page_cross, done, busy, pc_valid}), 0);
      chk("R10 cycles", int'(cycles), 0);
    end else begin
      chk("R1/R3/R4/R5 ea", int'(ea), m_ea);
      chk("R2 page_cross", int'(page_cross), int'(m_cross));
      chk("R2/R9 done", int'(done), int'(m_done));
      chk("R2 busy", int'(busy), int'(m_busy));
      chk("R6/R4 cycles", int'(cycles), m_cyc);
      chk("R7 pc_valid", int'(pc_valid), int'(m_phase == 2));
      chk("R7/R8 pc", int'(pc), m_pc);
      if (m_phase < 2) chk("R7 vec_rd", int'(vec_rd), 1);
    end
  end

  task automatic issue(input logic [1:0] md, input logic [15:0] b,
                       input logic [7:0] ix, input logic tk, input int hold);
    @(negedge clk);
    mode = md; base = b; index = ix; br_taken = tk; start = 1'b1;
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      base = b ^ 16'h5555; index = ix + 8'h77; mode = 2'd0;
    end
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    start = 1'b1; mode = 2'd3; base = 16'hBEEF;   // R9: ignored before pc_valid
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    pc_step = 1'b1; repeat (3) @(negedge clk); pc_step = 1'b0;   // R8
    issue(2'd0, 16'h12F0, 8'h20, 1'b0, 1);   // R1 R2 R6 cross
    issue(2'd0, 16'h1200, 8'h10, 1'b0, 1);   // R1 no cross
    issue(2'd0, 16'hFFFF, 8'h01, 1'b0, 1);   // R1 wrap
    issue(2'd1, 16'h00F0, 8'h20, 1'b0, 1);   // R3
    issue(2'd2, 16'h2010, 8'hF0, 1'b1, 1);   // R4 back, same page
    issue(2'd2, 16'h2005, 8'hF0, 1'b1, 1);   // R4 back, cross
    issue(2'd2, 16'h20F0, 8'h20, 1'b1, 1);   // R4 forward, cross
    issue(2'd2, 16'h20F0, 8'h20, 1'b0, 1);   // R4 not taken
    issue(2'd3, 16'h80FE, 8'hFF, 1'b0, 1);   // R5
    issue(2'd0, 16'h34FF, 8'hFF, 1'b0, 3);   // R9 start held through busy
    for (int n = 0; n < 300; n++) begin
      pc_step = $urandom_range(0, 1);
      issue(2'($urandom_range(0, 3)), 16'($urandom), 8'($urandom),
            1'($urandom_range(0, 1)), 1);
    end
    pc_step = 1'b0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule